// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Load-Use Stall Logic

This block is the hazard controller of a five-stage integer pipeline in which register operands are resolved in the Decode stage. Decode has two source operands: the rs side (operand A) and the rt side (operand B). For each one, the block produces a select code for the operand multiplexer. The code picks the register-file read value, the result now held in Execute, or the result now held in Memory.

There is no Writeback path. The register file returns a value that is being written in the same cycle, so Decode already sees it. A store takes its memory data from the operand-B path.

A load cannot supply its data before Memory. So when a load sits in Execute and Decode needs that load's destination register, the block raises two controls. The first holds the PC and the Fetch/Decode register. The second loads a no-op with every write enable low into the Decode/Execute register. The block is purely combinational. It decides from the current pipeline-register contents in the same cycle.

Top module: `hz_decode_fwd`

## Requirements
- R1: Each operand select is a 2-bit code: 2'b00 picks the register file, 2'b01 picks Execute, 2'b10 picks Memory. The code 2'b11 never appears.
- R2: An operand selects Execute (2'b01) when the Execute stage has its write enable high, is not a load, and its destination number equals the operand's nonzero source number.
- R3: An operand selects Memory (2'b10) when Memory has its write enable high, its destination equals the operand's nonzero source number, and Execute is not selected for that operand.
- R4: When Execute and Memory both match an operand and Execute is not a load, Execute wins.
- R5: A source number of 0 never selects Execute or Memory, and never causes a stall.
- R6: A stage whose write enable is low is never a producer. It neither forwards nor causes a stall, whatever its destination or load flag.
- R7: A load in Execute is never selected. When a load in Execute has its write enable high and its destination matches either nonzero source number, the hold output is 1. That operand then falls back to Memory if Memory matches, and otherwise to the register file.
- R8: The bubble output always equals the hold output. Both are 0 when no load-use hazard exists.
- R9: The two operand selects are decided independently. Each depends only on its own source number and the shared stage fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | REG_AW | Decode rs source register number (operand A) |
| src_b | input | REG_AW | Decode rt source register number (operand B, store data) |
| ex_dst | input | REG_AW | Destination register number in Execute |
| ex_wr | input | 1 | Register write enable in Execute |
| ex_is_load | input | 1 | Execute holds a load word |
| mem_dst | input | REG_AW | Destination register number in Memory |
| mem_wr | input | 1 | Register write enable in Memory |
| sel_a | output | 2 | Operand A select code |
| sel_b | output | 2 | Operand B select code |
| hold_front | output | 1 | Hold PC and Fetch/Decode register |
| bubble_ex | output | 1 | Load a no-op into Decode/Execute |

## Verification
A load-use stall caused by one operand can fall in the same cycle as a Memory or Execute forward on the other operand, or on the same operand. A single call to R7 also lands on R4's priority rule. The bench provokes every such overlap by sweeping all source numbers, destination numbers and stage flags of a 2-bit register-number configuration. For each combination it judges both selects and both stall controls against an arithmetic model. The model keeps stall detection apart from the choice of select.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_EX  = 2'b01,
      FWD_MEM = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
// Compares one producer stage against one consumer source number.
module hz_src_match #(
   parameter int unsigned REG_AW         = 5,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] dst,
   input  logic              wr,
   output logic              hit
);
   logic same;
   assign same = (src == dst);

   generate
      if (ZERO_REG_FIXED) begin : g_zero_fixed
         assign hit = wr && same && (src != '0);
      end else begin : g_zero_plain
         assign hit = wr && same;
      end
   endgenerate
endmodule

// File: rtl/hz_operand_sel.sv
// Chooses the operand source for one Decode operand.
module hz_operand_sel
   import hz_pkg::*;
#(
   parameter int unsigned REG_AW         = 5,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_wr,
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wr,
   output fwd_sel_e          sel,
   output logic              load_hazard
);
   logic ex_hit;
   logic mem_hit;
   logic ex_usable;

   hz_src_match #(.REG_AW(REG_AW), .ZERO_REG_FIXED(ZERO_REG_FIXED)) i_ex_match (
      .src(src), .dst(ex_dst), .wr(ex_wr), .hit(ex_hit)
   );

   hz_src_match #(.REG_AW(REG_AW), .ZERO_REG_FIXED(ZERO_REG_FIXED)) i_mem_match (
      .src(src), .dst(mem_dst), .wr(mem_wr), .hit(mem_hit)
   );

   // Load data only exists from Memory onward.
   assign ex_usable   = ex_hit && !ex_is_load;
   assign load_hazard = ex_hit &&  ex_is_load;

   always_comb begin
      if (ex_usable)    sel = FWD_EX;
      else if (mem_hit) sel = FWD_MEM;
      else              sel = FWD_RF;
   end
endmodule

// File: rtl/hz_stall_gen.sv
// Merges per-operand load hazards into front-end hold and Execute bubble.
module hz_stall_gen #(
   parameter int unsigned N_SRC = 2
) (
   input  logic [N_SRC-1:0] hazard,
   output logic             hold_front,
   output logic             bubble_ex
);
   logic any_hazard;
   assign any_hazard = |hazard;
   assign hold_front = any_hazard;
   assign bubble_ex  = any_hazard;
endmodule

// File: rtl/hz_decode_fwd.sv
module hz_decode_fwd
   import hz_pkg::*;
#(
   parameter int unsigned REG_AW         = 5,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_AW-1:0] src_a,
   input  logic [REG_AW-1:0] src_b,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_wr,
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wr,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b,
   output logic              hold_front,
   output logic              bubble_ex
);
   localparam int unsigned N_SRC = 2;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_width
         $error("hz_decode_fwd: REG_AW must be within 1..8");
      end
   endgenerate

   logic [REG_AW-1:0] src_vec [N_SRC];
   fwd_sel_e          sel_vec [N_SRC];
   logic [N_SRC-1:0]  hazard_vec;

   assign src_vec[0] = src_a;
   assign src_vec[1] = src_b;

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_operand
         hz_operand_sel #(.REG_AW(REG_AW), .ZERO_REG_FIXED(ZERO_REG_FIXED)) i_sel (
            .src        (src_vec[g]),
            .ex_dst     (ex_dst),
            .ex_wr      (ex_wr),
            .ex_is_load (ex_is_load),
            .mem_dst    (mem_dst),
            .mem_wr     (mem_wr),
            .sel        (sel_vec[g]),
            .load_hazard(hazard_vec[g])
         );
      end
   endgenerate

   assign sel_a = sel_vec[0];
   assign sel_b = sel_vec[1];

   hz_stall_gen #(.N_SRC(N_SRC)) i_stall (
      .hazard    (hazard_vec),
      .hold_front(hold_front),
      .bubble_ex (bubble_ex)
   );
endmodule

// File: rtl/hz_decode_fwd_chk.sv
module hz_decode_fwd_chk #(
   parameter int unsigned REG_AW         = 5,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input logic [REG_AW-1:0] src_a,
   input logic [REG_AW-1:0] src_b,
   input logic [REG_AW-1:0] ex_dst,
   input logic              ex_wr,
   input logic              ex_is_load,
   input logic [REG_AW-1:0] mem_dst,
   input logic              mem_wr,
   input logic [1:0]        sel_a,
   input logic [1:0]        sel_b,
   input logic              hold_front,
   input logic              bubble_ex
);
   always_comb begin
      if (!$isunknown({src_a, src_b, ex_dst, ex_wr, ex_is_load, mem_dst, mem_wr,
                       sel_a, sel_b, hold_front, bubble_ex})) begin
         a_r1_legal_code: assert (sel_a != 2'b11 && sel_b != 2'b11)
            else $error("R1 reserved select code");
         a_r2_ex_source_valid: assert (sel_a != 2'b01 || (ex_wr && !ex_is_load && ex_dst == src_a))
            else $error("R2 Execute select without matching producer");
         a_r3_mem_source_valid: assert (sel_b != 2'b10 || (mem_wr && mem_dst == src_b))
            else $error("R3 Memory select without matching producer");
         if (ZERO_REG_FIXED && src_a == '0) begin
            a_r5_zero_src: assert (sel_a == 2'b00)
               else $error("R5 register 0 forwarded");
         end
         if (!ex_wr && !mem_wr) begin
            a_r6_idle_producers: assert (sel_a == 2'b00 && sel_b == 2'b00 && !hold_front)
               else $error("R6 idle stages acted as producers");
         end
         if (ex_is_load) begin
            a_r7_load_not_source: assert (sel_a != 2'b01 && sel_b != 2'b01)
               else $error("R7 load in Execute selected");
         end
         a_r7_hold_needs_load: assert (!hold_front || (ex_is_load && ex_wr))
            else $error("R7 hold without load in Execute");
         a_r8_hold_eq_bubble: assert (hold_front == bubble_ex)
            else $error("R8 hold and bubble disagree");
      end
   end
endmodule

bind hz_decode_fwd hz_decode_fwd_chk #(.REG_AW(REG_AW), .ZERO_REG_FIXED(ZERO_REG_FIXED)) i_chk (
   .src_a(src_a), .src_b(src_b), .ex_dst(ex_dst), .ex_wr(ex_wr),
   .ex_is_load(ex_is_load), .mem_dst(mem_dst), .mem_wr(mem_wr),
   .sel_a(sel_a), .sel_b(sel_b), .hold_front(hold_front), .bubble_ex(bubble_ex)
);

// File: tb/test_hz_decode_fwd.sv
`timescale 1ns/1ps
module test_hz_decode_fwd;
   localparam int unsigned AW = 2;
   localparam int unsigned NR = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [AW-1:0] src_a, src_b, ex_dst, mem_dst;
   logic          ex_wr, ex_is_load, mem_wr;
   logic [1:0]    sel_a, sel_b;
   logic          hold_front, bubble_ex;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   hz_decode_fwd #(.REG_AW(AW), .ZERO_REG_FIXED(1'b1)) i_hz_decode_fwd (
      .src_a(src_a), .src_b(src_b), .ex_dst(ex_dst), .ex_wr(ex_wr),
      .ex_is_load(ex_is_load), .mem_dst(mem_dst), .mem_wr(mem_wr),
      .sel_a(sel_a), .sel_b(sel_b), .hold_front(hold_front), .bubble_ex(bubble_ex)
   );

   task automatic check(input string tag, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s: got %0d expected %0d (sa=%0d sb=%0d ed=%0d ew=%0d el=%0d md=%0d mw=%0d)",
                  tag, got, exp, src_a, src_b, ex_dst, ex_wr, ex_is_load, mem_dst, mem_wr);
      end
   endtask

   function automatic int exp_sel(int s, int ed, int ew, int el, int md, int mw);
      if (s == 0) return 0;
      if (ew == 1 && el == 0 && ed == s) return 1;
      if (mw == 1 && md == s) return 2;
      return 0;
   endfunction

   function automatic string sel_tag(int s, int e, int ed, int ew, int el);
      if (s == 0) return "R5";
      if (e == 1) return "R2";
      if (e == 2) return (ew == 1 && ed == s && el == 0) ? "R4" : "R3";
      if (ew == 1 && el == 1 && ed == s) return "R7";
      return "R6";
   endfunction

   initial begin
      src_a = '0; src_b = '0; ex_dst = '0; mem_dst = '0;
      ex_wr = 1'b0; ex_is_load = 1'b0; mem_wr = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 idle sel_a", int'(sel_a), 0);
      check("R6 idle sel_b", int'(sel_b), 0);
      check("R8 idle hold", int'(hold_front), 0);
      check("R8 idle bubble", int'(bubble_ex), 0);

      for (int sa = 0; sa < NR; sa++)
      for (int sb = 0; sb < NR; sb++)
      for (int ed = 0; ed < NR; ed++)
      for (int md = 0; md < NR; md++)
      for (int fl = 0; fl < 8; fl++) begin
         int ew, el, mw, ea, eb, eh;
         ew = fl & 1; el = (fl >> 1) & 1; mw = (fl >> 2) & 1;
         @(posedge clk);
         src_a = AW'(sa); src_b = AW'(sb); ex_dst = AW'(ed); mem_dst = AW'(md);
         ex_wr = ew[0]; ex_is_load = el[0]; mem_wr = mw[0];
         @(negedge clk);
         ea = exp_sel(sa, ed, ew, el, md, mw);
         eb = exp_sel(sb, ed, ew, el, md, mw);
         eh = (ew == 1 && el == 1 && ((sa != 0 && sa == ed) || (sb != 0 && sb == ed))) ? 1 : 0;
         check(sel_tag(sa, ea, ed, ew, el), int'(sel_a), ea);
         check((ea != eb) ? "R9" : sel_tag(sb, eb, ed, ew, el), int'(sel_b), eb);
         check("R1 code", int'(sel_a == 2'b11 || sel_b == 2'b11), 0);
         check("R7 hold", int'(hold_front), eh);
         check("R8 bubble", int'(bubble_ex), eh);
      end

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule